// File: doc/BRIEF.md
# Power Transition Time Stamp Capture

This block keeps two snapshots of the calendar time, covering seconds up to month. Each snapshot is taken when the chip changes power source. The down stamp records the switch from the main supply to the backup battery. The up stamp records the switch from the battery back to the main supply. A power monitor supplies one single-cycle strobe for each direction, and the live calendar supplies the current time as a packed 40-bit word.

The two stamps keep different events. The down stamp keeps the first switchover after a clear and ignores every later one until the next clear. The up stamp is rewritten on every switchover, so after a series of power cycles it holds the time of the most recent power-up. A clear command empties both stamps. An empty stamp reads as all zeros, including date and month. The live calendar never shows zero in those two fields, so a zero stamp tells software that no event has been captured.

The clear input carries a one-cycle write of the clear bit. The bit acts for that single cycle and then returns to zero on its own.

Top module: `pwr_stamp_keeper`

## Requirements
- R1: While reset is asserted, and right after it is released, both stamps read zero and the held flag reads 0.
- R2: A down strobe with the held flag at 0 loads the current time into the down stamp at the next clock edge. While the held flag is 1, further down strobes leave the down stamp unchanged.
- R3: Every up strobe loads the current time into the up stamp at the next clock edge. A later up strobe overwrites the earlier value.
- R4: A clear command sets both stamps to zero and the held flag to 0 at the next clock edge.
- R5: When a clear command and a strobe of either direction arrive in the same cycle, the clear wins and the stamp reads zero afterwards.
- R6: The held flag becomes 1 at the edge that captures a down stamp. It stays 1 until a clear command or reset.
- R7: Stamps keep the time word bit for bit. Bits [7:0] hold seconds, [15:8] minutes, [23:16] hours, [31:24] date and [39:32] month. Without a strobe, a stamp does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_time | input | 40 | Current calendar time, packed month..seconds |
| to_batt_stb | input | 1 | One-cycle strobe: supply-to-battery switchover |
| to_main_stb | input | 1 | One-cycle strobe: battery-to-supply switchover |
| clr_wr | input | 1 | Write of the clear bit, one cycle |
| down_stamp | output | 40 | Time of first switchover to battery |
| up_stamp | output | 40 | Time of latest switchover to main supply |
| down_held | output | 1 | Down stamp is occupied |

## Verification
Each stamp register drives an output port directly, so a wrong internal value shows at the ports one edge after the stimulus that caused it. A held flag that clears too early shows up as a down stamp overwritten by a later strobe. A held flag that never sets shows up as a down stamp that follows every strobe. A clear that loses to a same-cycle strobe leaves a non-zero stamp in the cycle after the clear.

// File: rtl/pwr_stamp_keeper.sv
module pwr_stamp_keeper #(
  parameter int FW = 8,
  parameter int NF = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FW*NF-1:0] now_time,
  input  logic             to_batt_stb,
  input  logic             to_main_stb,
  input  logic             clr_wr,
  output logic [FW*NF-1:0] down_stamp,
  output logic [FW*NF-1:0] up_stamp,
  output logic             down_held
);
  localparam int SW = FW * NF;

  logic take_down, take_up;

  assign take_down = to_batt_stb && !down_held && !clr_wr;
  assign take_up   = to_main_stb && !clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      down_stamp <= '0;
      down_held  <= 1'b0;
    end else if (clr_wr) begin
      down_stamp <= '0;
      down_held  <= 1'b0;
    end else if (take_down) begin
      down_stamp <= now_time;
      down_held  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        up_stamp <= {SW{1'b0}};
    else if (clr_wr)   up_stamp <= {SW{1'b0}};
    else if (take_up)  up_stamp <= now_time;
  end
endmodule

module pwr_stamp_keeper_chk #(
  parameter int FW = 8,
  parameter int NF = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [FW*NF-1:0] now_time,
  input logic             to_batt_stb,
  input logic             to_main_stb,
  input logic             clr_wr,
  input logic [FW*NF-1:0] down_stamp,
  input logic [FW*NF-1:0] up_stamp,
  input logic             down_held
);
  p_reset_empty_r1: assert property (@(posedge clk) !rst_n |-> (down_stamp == '0 && up_stamp == '0 && !down_held));
  p_clear_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (down_stamp == '0 && up_stamp == '0 && !down_held));
  p_first_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (to_batt_stb && !down_held && !clr_wr) |=> (down_stamp == $past(now_time) && down_held));
  p_keep_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (down_held && !clr_wr) |=> $stable(down_stamp));
  p_last_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (to_main_stb && !clr_wr) |=> (up_stamp == $past(now_time)));
  p_up_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_main_stb && !clr_wr) |=> $stable(up_stamp));
  p_held_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (down_held && !clr_wr) |=> down_held);
endmodule

bind pwr_stamp_keeper pwr_stamp_keeper_chk #(.FW(FW), .NF(NF)) i_chk (.*);

// File: tb/test_pwr_stamp_keeper.sv
module test_pwr_stamp_keeper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] now_time = '0;
  logic        to_batt_stb = 1'b0, to_main_stb = 1'b0, clr_wr = 1'b0;
  logic [39:0] down_stamp, up_stamp;
  logic        down_held;

  int errors = 0, checks = 0;
  logic [39:0] m_down = '0, m_up = '0;
  logic        m_held = 1'b0;
  bit          done = 0;

  always #10 clk = ~clk;

  pwr_stamp_keeper i_pwr_stamp_keeper (.*);

  function automatic logic [39:0] mk_time(int mo, int dt, int hr, int mi, int se);
    return {8'(mo), 8'(dt), 8'(hr), 8'(mi), 8'(se)};
  endfunction

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit dn, bit up, bit clr, logic [39:0] t, string req);
    to_batt_stb = dn; to_main_stb = up; clr_wr = clr; now_time = t;
    @(posedge clk);
    if (clr) begin m_down = '0; m_up = '0; m_held = 0; end
    else begin
      if (dn && !m_held) begin m_down = t; m_held = 1; end
      if (up) m_up = t;
    end
    @(negedge clk);
    to_batt_stb = 0; to_main_stb = 0; clr_wr = 0;
    chk({req, " down"}, down_stamp, m_down);
    chk({req, " up"}, up_stamp, m_up);
    chk({req, " held"}, {39'd0, down_held}, {39'd0, m_held});
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk);
    chk("R1 down", down_stamp, '0);
    chk("R1 up", up_stamp, '0);
    chk("R1 held", {39'd0, down_held}, 40'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {down_stamp, up_stamp}, '0);
    cyc(1, 0, 0, mk_time(8'h01, 8'h01, 8'h11, 8'h30, 8'h00), "R2 first");
    cyc(1, 0, 0, mk_time(8'h02, 8'h03, 8'h04, 8'h05, 8'h06), "R2 ignored");
    chk("R7 month field", {32'd0, down_stamp[39:32]}, 40'h01);
    chk("R7 minute field", {32'd0, down_stamp[15:8]}, 40'h30);
    cyc(0, 1, 0, mk_time(8'h12, 8'h31, 8'h23, 8'h59, 8'h59), "R3 one");
    cyc(0, 1, 0, mk_time(8'h06, 8'h15, 8'h08, 8'h00, 8'h01), "R3 last");
    cyc(0, 0, 0, mk_time(8'h07, 8'h07, 8'h07, 8'h07, 8'h07), "R7 quiet");
    cyc(1, 1, 1, mk_time(8'h09, 8'h09, 8'h09, 8'h09, 8'h09), "R5 clr wins");
    chk("R4 cleared", {down_stamp, up_stamp}, '0);
    chk("R6 held low", {39'd0, down_held}, 40'd0);
    cyc(1, 0, 0, mk_time(8'h03, 8'h04, 8'h05, 8'h06, 8'h07), "R6 retake");
    chk("R6 held set", {39'd0, down_held}, 40'd1);
    for (int i = 0; i < 3000; i++) begin
      logic [39:0] t;
      t = {8'($urandom_range(1, 18)), 8'($urandom_range(1, 49)), 8'($urandom_range(0, 35)),
           8'($urandom), 8'($urandom)};
      cyc($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 15) == 0, t,
          "R2/R3/R4 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule